// File: doc/BRIEF.md
# Dual-Tone Keypad Signal Generator

This block turns a 4-bit key code into a stream of signed digital samples that carry two sine tones at once: one from the low frequency group (697, 770, 852, 941 Hz) and one from the high group (1209, 1336, 1477, 1633 Hz). A system controller puts a code on `keyCode` and pulls the active-low enable `txEnN` to 0. The code is latched on that falling edge, and the tone keeps sounding for as long as the enable stays low. The code mapping is the same one a companion tone receiver uses on its code output, so the two can share one 4-bit bus.

Two 24-bit phase accumulators step once per sample strobe. The strobe is made by dividing the 3.579545 MHz core clock. Each accumulator reads its own copy of one quarter-wave sine table. The low-group sine is scaled down by one eighth, so the high group is slightly louder. The two are summed and clamped to the signed output width. Analog level trimming, smoothing and conversion happen outside the block.

Top module: `dtmf_tone_gen`

## Requirements
- R1: After reset, `sample` is 0 and `sampleValid` is 0. The latched code is 0000, so `lowStep` and `highStep` show the words for 941 Hz and 1633 Hz.
- R2: `keyCode` is latched only on the clock edge where `txEnN` is first seen low after being high. The new words appear on `lowStep`/`highStep` after that edge. Code changes at any other time have no effect on the steps.
- R3: Code-to-key mapping:
  - 0001 to 1001 select keys 1 to 9.
  - 1010 selects 0, 1011 selects `*` and 1100 selects `#`.
  - 1101, 1110 and 1111 select A, B and C.
  - 0000 selects D.
  - Keypad rows, from low to high frequency: {1,2,3,A}, {4,5,6,B}, {7,8,9,C}, {*,0,#,D}.
  - Keypad columns, from low to high frequency: {1,4,7,*}, {2,5,8,0}, {3,6,9,#}, {A,B,C,D}.
- R4: Each tuning word equals round(f · 2^PHASE_W · SAMPLE_DIV / CLK_HZ). The frequency it produces lies within ±1.5% of nominal.
- R5: While `txEnN` is 1, `sample` is 0 and `sampleValid` is 0 from the next clock edge on.
- R6: Both phases restart at zero on the falling enable edge. With the default table, the first valid sample after the fall is 94, made of 50 from the high group and 44 from the low group.
- R7: While `txEnN` stays low, `sampleValid` pulses once every SAMPLE_DIV clocks.
- R8: The sum is clamped to ±(2^(OUT_W-1)−1). With defaults this is ±2047, and the bound is reached during normal tones.
- R9: The low-group sine is the table value minus the table value shifted arithmetically right by 3. The high-group sine is the table value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (3.579545 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| txEnN | input | 1 | Active-low transmit enable; its falling edge latches the code |
| keyCode | input | 4 | Key code to send |
| sample | output | OUT_W | Signed dual-tone sample |
| sampleValid | output | 1 | One-clock pulse when a new sample is present |
| lowStep | output | PHASE_W | Low-group tuning word for the latched code |
| highStep | output | PHASE_W | High-group tuning word for the latched code |

## Verification
On every cycle, the in-line assertions check four things:
- silence follows a high enable;
- both phases are zero right after the falling edge;
- the latched code never moves except at that edge;
- samples never leave the clamp range, and strobes never come back to back.

The bench scenarios cover what a property cannot. They check the word values for all sixteen codes and the ±1.5% frequency accuracy. They check the exact first sample after phase restart, the spacing between samples, and that the clamp bound is actually reached. They also confirm that code changes are ignored both during a tone and between tones.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int LUT_W = 12;

  typedef struct packed {
    logic clearPhase;
    logic advance;
    logic silence;
  } dtmfCtrl_t;

  // row index of a key code (0 = lowest frequency)
  function automatic logic [1:0] keyRow(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13: keyRow = 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14: keyRow = 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15: keyRow = 2'd2;
      default:                 keyRow = 2'd3;
    endcase
  endfunction

  // column index of a key code (0 = lowest frequency)
  function automatic logic [1:0] keyCol(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11: keyCol = 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10: keyCol = 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12: keyCol = 2'd2;
      default:                 keyCol = 2'd3;
    endcase
  endfunction

  function automatic int toneHz(input bit highGroup, input int idx);
    int lowSet [4];
    int highSet [4];
    lowSet  = '{697, 770, 852, 941};
    highSet = '{1209, 1336, 1477, 1633};
    toneHz = highGroup ? highSet[idx] : lowSet[idx];
  endfunction

  function automatic longint tuneWord(input int hz, input int clkHz,
                                      input int div, input int phaseW);
    longint num;
    num = longint'(hz) * (longint'(1) << phaseW) * longint'(div);
    tuneWord = (num + longint'(clkHz / 2)) / longint'(clkHz);
  endfunction

endpackage

// File: rtl/dtmf_sine_lut.sv
module dtmf_sine_lut
  import dtmf_pkg::*;
(
  input  logic [6:0]              phaseTop,
  output logic signed [LUT_W-1:0] wave
);

  logic [4:0]       idx;
  logic [LUT_W-1:0] mag;

  function automatic logic [LUT_W-1:0] quarter(input logic [4:0] i);
    case (i)
      5'd0:  quarter = 12'd50;   5'd1:  quarter = 12'd151;
      5'd2:  quarter = 12'd251;  5'd3:  quarter = 12'd350;
      5'd4:  quarter = 12'd449;  5'd5:  quarter = 12'd546;
      5'd6:  quarter = 12'd642;  5'd7:  quarter = 12'd737;
      5'd8:  quarter = 12'd830;  5'd9:  quarter = 12'd920;
      5'd10: quarter = 12'd1009; 5'd11: quarter = 12'd1095;
      5'd12: quarter = 12'd1179; 5'd13: quarter = 12'd1259;
      5'd14: quarter = 12'd1337; 5'd15: quarter = 12'd1412;
      5'd16: quarter = 12'd1483; 5'd17: quarter = 12'd1550;
      5'd18: quarter = 12'd1614; 5'd19: quarter = 12'd1674;
      5'd20: quarter = 12'd1729; 5'd21: quarter = 12'd1781;
      5'd22: quarter = 12'd1828; 5'd23: quarter = 12'd1871;
      5'd24: quarter = 12'd1910; 5'd25: quarter = 12'd1944;
      5'd26: quarter = 12'd1973; 5'd27: quarter = 12'd1997;
      5'd28: quarter = 12'd2017; 5'd29: quarter = 12'd2032;
      5'd30: quarter = 12'd2041; default: quarter = 12'd2046;
    endcase
  endfunction

  always_comb begin
    idx  = phaseTop[5] ? ~phaseTop[4:0] : phaseTop[4:0];
    mag  = quarter(idx);
    wave = phaseTop[6] ? -$signed(mag) : $signed(mag);
  end

endmodule

// File: rtl/dtmf_ctrl.sv
module dtmf_ctrl
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ     = 3579545,
  parameter int SAMPLE_DIV = 448,
  parameter int PHASE_W    = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               txEnN,
  input  logic [3:0]         keyCode,
  output dtmfCtrl_t          ctrl,
  output logic [PHASE_W-1:0] lowStep,
  output logic [PHASE_W-1:0] highStep
);

  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);

  logic             txEnQ;
  logic             fall;
  logic [3:0]       codeReg;
  logic [CNT_W-1:0] divCnt;
  logic             strobe;
  logic [PHASE_W-1:0] lowTab  [4];
  logic [PHASE_W-1:0] highTab [4];

  for (genvar g = 0; g < 4; g++) begin : gWords
    assign lowTab[g]  = PHASE_W'(tuneWord(toneHz(1'b0, g), CLK_HZ, SAMPLE_DIV, PHASE_W));
    assign highTab[g] = PHASE_W'(tuneWord(toneHz(1'b1, g), CLK_HZ, SAMPLE_DIV, PHASE_W));
  end

  assign fall   = txEnQ & ~txEnN;
  assign strobe = (divCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnQ   <= 1'b1;
      codeReg <= 4'd0;
      divCnt  <= '0;
    end else begin
      txEnQ  <= txEnN;
      divCnt <= strobe ? '0 : divCnt + 1'b1;
      if (fall) codeReg <= keyCode;
    end
  end

  always_comb begin
    ctrl.clearPhase = fall;
    ctrl.advance    = strobe & ~txEnN & ~fall;
    ctrl.silence    = txEnN;
    lowStep         = lowTab[keyRow(codeReg)];
    highStep        = highTab[keyCol(codeReg)];
  end

  assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !fall |=> $stable(codeReg));

  assert_strobe_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> !strobe);

endmodule

// File: rtl/dtmf_datapath.sv
module dtmf_datapath
  import dtmf_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dtmfCtrl_t               ctrl,
  input  logic [PHASE_W-1:0]      lowStep,
  input  logic [PHASE_W-1:0]      highStep,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sampleValid
);

  localparam int SUM_W   = LUT_W + 1;
  localparam int SAT_MAX = (1 << (OUT_W - 1)) - 1;

  logic [PHASE_W-1:0]      step  [2];
  logic [PHASE_W-1:0]      phase [2];
  logic signed [LUT_W-1:0] wave  [2];
  logic signed [LUT_W-1:0] lowScaled;
  logic signed [SUM_W-1:0] sumV;
  logic signed [OUT_W-1:0] satV;

  assign step[0] = lowStep;
  assign step[1] = highStep;

  for (genvar g = 0; g < 2; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rstN)               phase[g] <= '0;
      else if (ctrl.clearPhase) phase[g] <= '0;
      else if (ctrl.advance)    phase[g] <= phase[g] + step[g];
    end

    dtmf_sine_lut lut_i (
      .phaseTop (phase[g][PHASE_W-1 -: 7]),
      .wave     (wave[g])
    );
  end

  always_comb begin
    int s;
    lowScaled = wave[0] - (wave[0] >>> 3);
    sumV = SUM_W'(lowScaled) + SUM_W'(wave[1]);
    s = int'(sumV);
    if (s > SAT_MAX)       s = SAT_MAX;
    else if (s < -SAT_MAX) s = -SAT_MAX;
    satV = OUT_W'(s);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sample      <= '0;
      sampleValid <= 1'b0;
    end else if (ctrl.silence) begin
      sample      <= '0;
      sampleValid <= 1'b0;
    end else if (ctrl.advance) begin
      sample      <= satV;
      sampleValid <= 1'b1;
    end else begin
      sampleValid <= 1'b0;
    end
  end

  assert_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.silence |=> (sample == '0) && !sampleValid);

  assert_phase_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clearPhase |=> (phase[0] == '0) && (phase[1] == '0));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sample) <= SAT_MAX) && (int'(sample) >= -SAT_MAX));

endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_pkg::*;
#(
  parameter int CLK_HZ     = 3579545,
  parameter int SAMPLE_DIV = 448,
  parameter int PHASE_W    = 24,
  parameter int OUT_W      = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    txEnN,
  input  logic [3:0]              keyCode,
  output logic signed [OUT_W-1:0] sample,
  output logic                    sampleValid,
  output logic [PHASE_W-1:0]      lowStep,
  output logic [PHASE_W-1:0]      highStep
);

  dtmfCtrl_t ctrl;

  dtmf_ctrl #(
    .CLK_HZ     (CLK_HZ),
    .SAMPLE_DIV (SAMPLE_DIV),
    .PHASE_W    (PHASE_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .txEnN    (txEnN),
    .keyCode  (keyCode),
    .ctrl     (ctrl),
    .lowStep  (lowStep),
    .highStep (highStep)
  );

  dtmf_datapath #(
    .PHASE_W (PHASE_W),
    .OUT_W   (OUT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .lowStep     (lowStep),
    .highStep    (highStep),
    .sample      (sample),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/dtmf_tone_gen_tb_top.sv
`timescale 1ns/1ps
module dtmf_tone_gen_tb_top;

  localparam int CLK_HZ  = 3579545;
  localparam int DIV     = 112;
  localparam int PW      = 24;
  localparam int OW      = 12;
  localparam int NSAMP   = 40;
  localparam int SAT     = 2047;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnN = 1'b1;
  logic [3:0] keyCode = 4'd0;
  logic signed [OW-1:0] sample;
  logic sampleValid;
  logic [PW-1:0] lowStep, highStep;

  int checks = 0;
  int errors = 0;
  longint cycle = 0;
  int maxS = -100000;
  int minS = 100000;

  typedef struct { int code; longint lowW; longint highW; } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  dtmf_tone_gen #(.CLK_HZ(CLK_HZ), .SAMPLE_DIV(DIV), .PHASE_W(PW), .OUT_W(OW)) dut_i (
    .clk(clk), .rstN(rstN), .txEnN(txEnN), .keyCode(keyCode),
    .sample(sample), .sampleValid(sampleValid),
    .lowStep(lowStep), .highStep(highStep)
  );

  function automatic longint refWord(input int hz);
    real w;
    w = real'(hz) * (2.0 ** PW) * real'(DIV) / real'(CLK_HZ);
    return longint'($floor(w + 0.5));
  endfunction

  // reference keypad (R3): row/column Hz by code
  function automatic int refLowHz(input int code);
    case (code)
      1, 2, 3, 13: return 697;
      4, 5, 6, 14: return 770;
      7, 8, 9, 15: return 852;
      default:     return 941;
    endcase
  endfunction

  function automatic int refHighHz(input int code);
    case (code)
      1, 4, 7, 11: return 1209;
      2, 5, 8, 10: return 1336;
      3, 6, 9, 12: return 1477;
      default:     return 1633;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic accuracy(input longint word, input int hz, input string req);
    real f, err;
    f = real'(word) * real'(CLK_HZ) / real'(DIV) / (2.0 ** PW);
    err = (f - real'(hz)) / real'(hz);
    if (err < 0.0) err = -err;
    check(err <= 0.015, req, longint'(f), hz);
  endtask

  // driver: pushes expectation, plays one key, optionally tests ignore-while-low
  task automatic playKey(input int code, input bit poke);
    expItem_t it;
    longint lw, hw;
    lw = refWord(refLowHz(code));
    hw = refWord(refHighHz(code));
    it.code = code; it.lowW = lw; it.highW = hw;
    expQ.push_back(it);
    @(negedge clk);
    keyCode = 4'(code);
    txEnN = 1'b0;
    repeat (NSAMP * DIV / 2) @(negedge clk);
    if (poke) begin
      keyCode = 4'(code ^ 5);
      repeat (3) @(negedge clk);
      check(lowStep == PW'(lw) && highStep == PW'(hw), "R2 change while low", lowStep, lw);
    end
    repeat (NSAMP * DIV / 2) @(negedge clk);
    txEnN = 1'b1;
    @(negedge clk);
    check(sample == 0 && !sampleValid, "R5 silent after release", sample, 0);
    keyCode = 4'(code ^ 9);
    repeat (DIV + 4) @(negedge clk);
    check(sample == 0 && !sampleValid, "R5 stays silent", sample, 0);
    check(lowStep == PW'(lw) && highStep == PW'(hw), "R2 change while high", highStep, hw);
  endtask

  // monitor: pops on first sample of a burst, checks spacing afterwards
  initial begin
    longint lastV = -1;
    forever begin
      @(negedge clk);
      if (sampleValid) begin
        if (int'(sample) > maxS) maxS = int'(sample);
        if (int'(sample) < minS) minS = int'(sample);
        if (expQ.size() > 0) begin
          expItem_t it;
          it = expQ.pop_front();
          check(longint'(lowStep) == it.lowW, $sformatf("R3 R4 low word code %0d", it.code), lowStep, it.lowW);
          check(longint'(highStep) == it.highW, $sformatf("R3 R4 high word code %0d", it.code), highStep, it.highW);
          check(sample == 94, "R6 R9 first sample after fall", sample, 94);
          accuracy(longint'(lowStep), refLowHz(it.code), "R4 low accuracy");
          accuracy(longint'(highStep), refHighHz(it.code), "R4 high accuracy");
        end else if (lastV >= 0) begin
          check(cycle - lastV == DIV, "R7 sample spacing", cycle - lastV, DIV);
        end
        lastV = cycle;
      end else if (txEnN) begin
        lastV = -1;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        check(sample == 0 && !sampleValid, "R1 reset output", sample, 0);
        check(longint'(lowStep) == refWord(941), "R1 reset low word", lowStep, refWord(941));
        check(longint'(highStep) == refWord(1633), "R1 reset high word", highStep, refWord(1633));
        for (int k = 0; k < 16; k++) playKey((k * 7 + 3) % 16, (k % 5) == 0);
        check(maxS == SAT, "R8 clamp reached", maxS, SAT);
        check(minS >= -SAT, "R8 lower bound", minS, -SAT);
        check(expQ.size() == 0, "R6 every burst produced samples", expQ.size(), 0);
      end
      begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog", cycle, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule